// File: doc/BRIEF.md
# Serial Receive Device on the I/O Transfer Bus

This block is a peripheral for a 12-bit processor. The processor runs I/O transfer (IOT) instructions to talk to devices, and this block answers those instructions. It contains its own 8N1 serial receiver, which uses sixteen-times oversampling. When a character arrives, the block stores it and raises a receive flag. Software can then test that flag with a skip instruction, move the character into the accumulator, clear the flag, and allow an interrupt request that stays asserted while a character is waiting. A second device number, the one adjacent to the receiver's, holds a transmit-ready flag. Software can test, clear and set that flag, but the block has no transmit shift logic.

The instruction word is decoded as follows. Bits [11:9] must hold the IOT opcode 3'b110. Bits [8:3] hold the device number. Bits [2:0] hold three operation bits, with bit 0 having weight 1. The block drives its response outputs combinationally in the same cycle that the strobe is high. Any state change caused by the instruction takes effect at the following clock edge. The serial line runs at 9600 baud by default, and the bit timing is derived from the clock frequency parameter.

Top module: `iot_serial_rx_dev`

## Requirements
- R1: The block responds only while `iot_strobe` is high, `iot_instr[11:9]` is 3'b110 and `iot_instr[8:3]` equals RX_DEV (default octal 43) or TX_DEV (default octal 44). At any other time `skip_req`, `ac_load` and `ac_clr` are low and no flag changes.
- R2: The receiver deserializes 8N1 frames, least significant bit first, sampling each bit at its centre with sixteen-times oversampling. A frame with a high stop bit stores the character and sets the receive flag.
- R3: A low pulse on `rx` shorter than half a bit does not start a frame. A frame whose stop bit is low is discarded and leaves the receive flag unchanged.
- R4: On the receive device, operation bit weight 1 asserts `skip_req` exactly when the receive flag is set, except for operation code 5 (octal 6431 with the default device).
- R5: On the receive device, operation bit weight 2 asserts `ac_clr` and `ac_load` and clears the receive flag (octal 6432 and 6436).
- R6: On the receive device, operation bit weight 4 asserts `ac_load`, except for operation code 5. In that case `ac_data` is the stored character in bits [7:0] with bits [11:8] zero, ORed with `ac_in` unless weight 2 is also set, in which case it is ORed with zero.
- R7: Operation code 5 on the receive device (octal 6435) loads the interrupt enable from `ac_in[0]`. It asserts neither `skip_req` nor `ac_load`.
- R8: `irq` is high exactly while the interrupt enable and the receive flag are both set.
- R9: A character that completes while the receive flag is already set overwrites the stored character and keeps the flag set. A character that completes in the same cycle as a flag clear also wins.
- R10: On the transmit device, weight 1 skips when the transmit flag is set. Weight 2 clears the transmit flag and asserts `ac_clr` and `ac_load` with `ac_data` zero (octal 6442). Weight 4 sets the transmit flag and takes precedence over weight 2.
- R11: After reset the receive flag, the interrupt enable and the stored character are zero, the transmit flag is one, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_strobe | input | 1 | High for one cycle while an IOT instruction is presented |
| iot_instr | input | 12 | Instruction word |
| ac_in | input | 12 | Current accumulator value |
| rx | input | 1 | Serial receive line, idle high |
| skip_req | output | 1 | Skip the next instruction |
| ac_load | output | 1 | Accumulator takes `ac_data` |
| ac_data | output | 12 | New accumulator value |
| ac_clr | output | 1 | Instruction cleared the accumulator |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the strobe to be a single-cycle pulse for each instruction, with the instruction word and accumulator stable while the strobe is high. They also take a flag clear to be judged only in cycles where no character completes. The bench drives every IOT input at the falling edge and drops the strobe one cycle later. It places serial frames far enough apart from instructions that a clear never meets a completing character. The same-cycle precedence case of R9 is therefore left to the assertion.

// File: rtl/iot_rx_pkg.sv
package iot_rx_pkg;
    localparam int AC_W    = 12;
    localparam int DEV_W   = 6;
    localparam int OP_W    = 3;
    localparam int CHAR_W  = 8;
    localparam int OVS     = 16;
    localparam int PH_W    = $clog2(OVS);
    localparam int NB_W    = $clog2(CHAR_W);
    localparam logic [AC_W-DEV_W-OP_W-1:0] IOT_OPC = 3'b110;
    localparam logic [OP_W-1:0] OP_IE = 3'd5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [PH_W-1:0]    ph;
        logic [NB_W-1:0]    nbit;
        logic [CHAR_W-1:0]  sh;
        logic [1:0]         sync;
        logic               done;
    } deser_t;

    typedef struct packed {
        logic               rx_flag;
        logic               ie;
        logic               tx_flag;
        logic [CHAR_W-1:0]  held;
    } dev_t;
endpackage

// File: rtl/iot_rx_baud.sv
module iot_rx_baud #(
    parameter int DIV = 325
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
            tick  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/iot_rx_deser.sv
module iot_rx_deser
    import iot_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    output logic              char_done,
    output logic [CHAR_W-1:0] rx_char
);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [NB_W-1:0] NB_LAST = NB_W'(CHAR_W - 1);

    deser_t d, q;
    logic   rx_s;

    assign rx_s = q.sync[1];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sync = {q.sync[0], rx};
        if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        d.st = RX_START;
                        d.ph = '0;
                    end
                end
                RX_START: begin
                    if (q.ph == PH_MID) begin
                        d.ph   = '0;
                        d.nbit = '0;
                        d.st   = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.ph == PH_LAST) begin
                        d.ph = '0;
                        d.sh = {rx_s, q.sh[CHAR_W-1:1]};
                        if (q.nbit == NB_LAST) d.st = RX_STOP;
                        else                   d.nbit = q.nbit + 1'b1;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.ph == PH_LAST) begin
                        d.ph = '0;
                        if (rx_s) begin
                            d.done = 1'b1;
                            d.st   = RX_IDLE;
                        end else begin
                            d.st = RX_WAIT_HIGH;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (rx_s) d.st = RX_IDLE;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign char_done = q.done;
    assign rx_char   = q.sh;
endmodule

// File: rtl/iot_serial_rx_dev.sv
module iot_serial_rx_dev
    import iot_rx_pkg::*;
#(
    parameter int              CLK_HZ = 50_000_000,
    parameter int              BAUD   = 9600,
    parameter logic [DEV_W-1:0] RX_DEV = 6'o43,
    parameter logic [DEV_W-1:0] TX_DEV = 6'o44
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iot_strobe,
    input  logic [AC_W-1:0] iot_instr,
    input  logic [AC_W-1:0] ac_in,
    input  logic            rx,
    output logic            skip_req,
    output logic            ac_load,
    output logic [AC_W-1:0] ac_data,
    output logic            ac_clr,
    output logic            irq
);
    localparam int DIV = CLK_HZ / (BAUD * OVS);

    logic              tick;
    logic              char_done;
    logic [CHAR_W-1:0] rx_char;
    logic              rx_flag_w;

    iot_rx_baud #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    iot_rx_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx        (rx),
        .char_done (char_done),
        .rx_char   (rx_char)
    );

    dev_t            d, q;
    logic            is_iot, hit_rx, hit_tx, ie_op, rd_op;
    logic [OP_W-1:0] op;

    always_comb begin
        op     = iot_instr[OP_W-1:0];
        is_iot = iot_strobe && (iot_instr[AC_W-1:DEV_W+OP_W] == IOT_OPC);
        hit_rx = is_iot && (iot_instr[DEV_W+OP_W-1:OP_W] == RX_DEV);
        hit_tx = is_iot && (iot_instr[DEV_W+OP_W-1:OP_W] == TX_DEV);
        ie_op  = hit_rx && (op == OP_IE);
        rd_op  = hit_rx && op[2] && !ie_op;

        skip_req = (hit_rx && op[0] && !ie_op && q.rx_flag)
                 || (hit_tx && op[0] && q.tx_flag);
        ac_clr   = (hit_rx || hit_tx) && op[1];
        ac_load  = ac_clr || rd_op;
        ac_data  = '0;
        if (ac_load) begin
            ac_data = ac_clr ? '0 : ac_in;
            if (rd_op) ac_data = ac_data | {{(AC_W-CHAR_W){1'b0}}, q.held};
        end

        d = q;
        if (hit_rx && op[1]) d.rx_flag = 1'b0;
        if (char_done) begin
            d.rx_flag = 1'b1;
            d.held    = rx_char;
        end
        if (ie_op) d.ie = ac_in[0];
        if (hit_tx && op[1]) d.tx_flag = 1'b0;
        if (hit_tx && op[2]) d.tx_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.tx_flag <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_flag_w = q.rx_flag;
    assign irq       = q.ie && q.rx_flag;
endmodule

// File: rtl/iot_rx_dev_chk.sv
module iot_rx_dev_chk
    import iot_rx_pkg::*;
#(
    parameter logic [DEV_W-1:0] RX_DEV = 6'o43
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iot_strobe,
    input logic [AC_W-1:0] iot_instr,
    input logic            skip_req,
    input logic            ac_load,
    input logic [AC_W-1:0] ac_data,
    input logic            ac_clr,
    input logic            irq,
    input logic            char_done,
    input logic            rx_flag
);
    logic rx_hit, rx_clear;

    assign rx_hit   = iot_strobe && iot_instr[AC_W-1:DEV_W+OP_W] == IOT_OPC
                      && iot_instr[DEV_W+OP_W-1:OP_W] == RX_DEV;
    assign rx_clear = rx_hit && iot_instr[1];

    // R1
    no_resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iot_strobe |-> !skip_req && !ac_load && !ac_clr);

    // R2
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_flag);

    // R5
    rx_clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear && !char_done |=> !rx_flag);

    // R6
    char_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ac_load && ac_clr |-> ac_data[AC_W-1:CHAR_W] == '0);

    // R7
    ie_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit && iot_instr[OP_W-1:0] == OP_IE |-> !ac_load && !skip_req);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clear && !char_done |=> !irq);

    // R9
    keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && !rx_clear |=> rx_flag);
endmodule

bind iot_serial_rx_dev iot_rx_dev_chk #(.RX_DEV(RX_DEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iot_strobe (iot_strobe),
    .iot_instr  (iot_instr),
    .skip_req   (skip_req),
    .ac_load    (ac_load),
    .ac_data    (ac_data),
    .ac_clr     (ac_clr),
    .irq        (irq),
    .char_done  (char_done),
    .rx_flag    (rx_flag_w)
);

// File: tb/test_iot_serial_rx_dev.sv
`timescale 1ns/100ps
module test_iot_serial_rx_dev;
    localparam int TB_CLK_HZ = 16_000_000;
    localparam int TB_BAUD   = 250_000;
    localparam int BIT       = TB_CLK_HZ / TB_BAUD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iot_strobe = 1'b0;
    logic [11:0] iot_instr = '0;
    logic [11:0] ac_in = '0;
    logic        rx = 1'b1;
    logic        skip_req, ac_load, ac_clr, irq;
    logic [11:0] ac_data;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    logic [12:0] exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    iot_serial_rx_dev #(.CLK_HZ(TB_CLK_HZ), .BAUD(TB_BAUD)) i_iot_serial_rx_dev (
        .clk(clk), .rst_n(rst_n), .iot_strobe(iot_strobe), .iot_instr(iot_instr),
        .ac_in(ac_in), .rx(rx), .skip_req(skip_req), .ac_load(ac_load),
        .ac_data(ac_data), .ac_clr(ac_clr), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_run) begin
            done_run = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops one expected accumulator result per load cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (ac_load) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected load", {19'd0, ac_clr, ac_data}, 0);
                end else begin
                    logic [12:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk({ac_clr, ac_data} == e, r, {19'd0, ac_clr, ac_data}, {19'd0, e});
                end
            end
        end
    end

    // driver: one IOT instruction, strobe for one cycle
    task automatic iot(input bit stb, input logic [11:0] ins, input logic [11:0] ac,
                       input bit exp_skip, input bit exp_load, input bit exp_clr,
                       input logic [11:0] exp_val, input string req);
        @(negedge clk);
        if (exp_load) begin
            exp_q.push_back({exp_clr, exp_val});
            req_q.push_back(req);
        end
        iot_strobe = stb;
        iot_instr  = ins;
        ac_in      = ac;
        #1;
        chk(skip_req == exp_skip, req, skip_req, exp_skip);
        if (!exp_load) chk(ac_load == 1'b0, req, ac_load, 0);
        @(negedge clk);
        iot_strobe = 1'b0;
        iot_instr  = '0;
    endtask

    task automatic check_irq(input bit e, input string req);
        @(negedge clk);
        #1;
        chk(irq == e, req, irq, e);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        logic [9:0] fr;
        fr = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rx = fr[i];
            repeat (BIT) @(negedge clk);
        end
        rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (BIT) @(negedge clk);

        // reset state
        check_irq(1'b0, "R11 irq after reset");
        iot(1, 12'o6431, 0, 0, 0, 0, 0, "R11 rx flag clear after reset");
        iot(1, 12'o6441, 0, 1, 0, 0, 0, "R11 tx flag set after reset");

        // receive and decode
        send_frame(8'h55, 1);
        iot(1, 12'o6431, 0, 1, 0, 0, 0, "R2 R4 skip on received char");
        iot(1, 12'o6531, 0, 0, 0, 0, 0, "R1 other device ignored");
        iot(1, 12'o2431, 0, 0, 0, 0, 0, "R1 non-IOT opcode ignored");
        iot(0, 12'o6431, 0, 0, 0, 0, 0, "R1 no strobe no skip");
        iot(0, 12'o6436, 0, 0, 0, 0, 0, "R1 no strobe no read");
        iot(1, 12'o6431, 0, 1, 0, 0, 0, "R1 flag kept without strobe");
        iot(1, 12'o6434, 12'h300, 0, 1, 0, 12'h355, "R6 OR char into AC");
        iot(1, 12'o6431, 0, 1, 0, 0, 0, "R6 OR read keeps flag");
        iot(1, 12'o6436, 12'h7FF, 0, 1, 1, 12'h055, "R5 R6 read and clear");
        iot(1, 12'o6431, 0, 0, 0, 0, 0, "R5 flag cleared by read");

        // overrun
        send_frame(8'hC3, 1);
        send_frame(8'h3C, 1);
        iot(1, 12'o6431, 0, 1, 0, 0, 0, "R9 flag kept on overrun");
        iot(1, 12'o6436, 0, 0, 1, 1, 12'h03C, "R9 newest char kept");

        // clear only
        send_frame(8'h81, 1);
        iot(1, 12'o6432, 12'h123, 0, 1, 1, 12'h000, "R5 clear flag and AC");
        iot(1, 12'o6431, 0, 0, 0, 0, 0, "R5 flag cleared by 6432");

        // interrupt
        iot(1, 12'o6435, 12'h001, 0, 0, 0, 0, "R7 enable op quiet");
        check_irq(1'b0, "R8 no irq without flag");
        send_frame(8'h0F, 1);
        check_irq(1'b1, "R8 irq with enable and flag");
        iot(1, 12'o6436, 0, 0, 1, 1, 12'h00F, "R8 read under interrupt");
        check_irq(1'b0, "R8 irq drops after read");
        iot(1, 12'o6435, 12'hFFE, 0, 0, 0, 0, "R7 disable from AC bit 0");
        send_frame(8'hF0, 1);
        check_irq(1'b0, "R7 irq masked");
        iot(1, 12'o6431, 0, 1, 0, 0, 0, "R7 flag set while masked");
        iot(1, 12'o6436, 0, 0, 1, 1, 12'h0F0, "R2 masked char read");

        // line faults
        rx = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        iot(1, 12'o6431, 0, 0, 0, 0, 0, "R3 start glitch ignored");
        send_frame(8'hA5, 0);
        iot(1, 12'o6431, 0, 0, 0, 0, 0, "R3 bad stop discarded");
        send_frame(8'h99, 1);
        iot(1, 12'o6436, 0, 0, 1, 1, 12'h099, "R2 R3 recovery after fault");

        // transmit flag
        iot(1, 12'o6442, 12'h456, 0, 1, 1, 12'h000, "R10 clear tx flag and AC");
        iot(1, 12'o6441, 0, 0, 0, 0, 0, "R10 tx flag cleared");
        iot(1, 12'o6444, 12'h456, 0, 0, 0, 0, "R10 set tx flag");
        iot(1, 12'o6441, 0, 1, 0, 0, 0, "R10 tx flag set again");
        iot(1, 12'o6446, 12'h456, 0, 1, 1, 12'h000, "R10 set wins over clear");
        iot(1, 12'o6441, 0, 1, 0, 0, 0, "R10 tx flag after 6446");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected loads seen", exp_q.size(), 0);
        summary();
    end
endmodule